// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement Tracker

This block keeps replacement history for every set of a 4-way set-associative cache. Three history bits per set form a small binary tree. The root bit says which pair of ways, {0,1} or {2,3}, was used less recently. Each of the two leaf-pair bits chooses between the two ways inside its pair. Every hit and every fill reported on the update port rewrites the bits of the set it names. The victim port decodes the bits of a separately queried set into the way to evict on a miss.

The cache controller reports each hit, and each fill into the victim way, as one update. It reads the victim for the set that missed. The victim output is combinational from the stored bits, so it shows the state before any update in the same cycle. Tag comparison and data storage belong to other blocks.

Top module: `plru4_tracker`

## Requirements
- R1: After reset has been released and two more clock edges have passed, every set holds tree bits 000, so the victim is way 0 for every queried set. Way encoding is 0=A, 1=B, 2=C, 3=D. The tree bits are written {cd, ab, root}, with root as bit 0.
- R2: Victim decode: when root=0, the victim is way 0 if ab=0 and way 1 if ab=1. When root=1, the victim is way 2 if cd=0 and way 3 if cd=1.
- R3: An update to way 0 sets ab=1 and root=1. An update to way 1 sets ab=0 and root=1. In both cases cd is unchanged.
- R4: Starting from state 000, an update to way 1 leaves state 001, so the next victim is way 2.
- R5: An update to way 2 sets cd=1 and root=0. An update to way 3 sets cd=0 and root=0. In both cases ab is unchanged.
- R6: An update changes only the set named on upd_set. The victim of every other set is unchanged.
- R7: While upd_valid is low, no set changes.
- R8: victim_way reflects the stored state of qry_set before any update in the same cycle. The effect of an update is visible from the following cycle.
- R9: Right after an update to way w of a set, the victim of that set is never w.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_valid | input | 1 | Hit or fill strobe for this cycle |
| upd_set | input | SET_W | Set index of the hit or fill |
| upd_way | input | 2 | Way that was hit or filled |
| qry_set | input | SET_W | Set whose victim is requested |
| victim_way | output | 2 | Way to replace in qry_set |

## Verification
The hard case is a tree state in which both the root bit and a leaf bit disagree with what the most recent access alone would imply. One example is state 111, where victim D can only come from an earlier C hit followed by an A hit. Such states need a specific order of accesses to one set. Directed sequences walk one set through C, D, B, C and A hits so that every decode branch is reached. A long pseudo-random run then mixes sets, ways and idle cycles, comparing each victim against an arithmetic tree model. It also queries the just-updated set on alternate cycles so that the same-cycle view and the "never the last way" rule are both exercised.

// File: rtl/plru4_pkg.sv
package plru4_pkg;

  typedef logic [1:0] way_t;

  // cd chooses between ways 2/3, ab between 0/1, root between the pairs
  typedef struct packed {
    logic cd;
    logic ab;
    logic root;
  } tree_t;

  localparam way_t WAY_A = 2'd0;
  localparam way_t WAY_B = 2'd1;
  localparam way_t WAY_C = 2'd2;
  localparam way_t WAY_D = 2'd3;

endpackage

// File: rtl/plru4_rst_sync.sv
module plru4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/plru4_tree_next.sv
module plru4_tree_next
  import plru4_pkg::*;
(
  input  tree_t cur,
  input  way_t  way,
  output tree_t nxt
);

  always_comb begin
    nxt = cur;
    unique case (way)
      WAY_A: begin nxt.ab = 1'b1; nxt.root = 1'b1; end
      WAY_B: begin nxt.ab = 1'b0; nxt.root = 1'b1; end
      WAY_C: begin nxt.cd = 1'b1; nxt.root = 1'b0; end
      WAY_D: begin nxt.cd = 1'b0; nxt.root = 1'b0; end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/plru4_tree_victim.sv
module plru4_tree_victim
  import plru4_pkg::*;
(
  input  tree_t cur,
  output way_t  victim
);

  always_comb begin
    if (cur.root) victim = cur.cd ? WAY_D : WAY_C;
    else          victim = cur.ab ? WAY_B : WAY_A;
  end

endmodule

// File: rtl/plru4_set_bank.sv
module plru4_set_bank
  import plru4_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  tree_t            wr_bits,
  input  logic [SET_W-1:0] rd_a_set,
  output tree_t            rd_a_bits,
  input  logic [SET_W-1:0] rd_b_set,
  output tree_t            rd_b_bits
);

  tree_t bits_q [NUM_SETS];
  tree_t bits_d [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_en;

    always_comb begin
      set_en    = wr_en && (wr_set == SET_W'(s));
      bits_d[s] = set_en ? wr_bits : bits_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[s] <= '0;
      else        bits_q[s] <= bits_d[s];
    end
  end

  always_comb begin
    rd_a_bits = '0;
    rd_b_bits = '0;
    if (int'(rd_a_set) < NUM_SETS) rd_a_bits = bits_q[rd_a_set];
    if (int'(rd_b_set) < NUM_SETS) rd_b_bits = bits_q[rd_b_set];
  end

endmodule

// File: rtl/plru4_tracker.sv
module plru4_tracker
  import plru4_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [SET_W-1:0] upd_set,
  input  logic [1:0]       upd_way,
  input  logic [SET_W-1:0] qry_set,
  output logic [1:0]       victim_way
);

  logic  rst_sync_n;
  tree_t qry_bits;
  tree_t upd_cur;
  tree_t upd_nxt;
  way_t  victim_w;

  plru4_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  plru4_set_bank #(.NUM_SETS(NUM_SETS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (upd_valid),
    .wr_set    (upd_set),
    .wr_bits   (upd_nxt),
    .rd_a_set  (qry_set),
    .rd_a_bits (qry_bits),
    .rd_b_set  (upd_set),
    .rd_b_bits (upd_cur)
  );

  plru4_tree_next u_next (
    .cur (upd_cur),
    .way (way_t'(upd_way)),
    .nxt (upd_nxt)
  );

  plru4_tree_victim u_victim (
    .cur    (qry_bits),
    .victim (victim_w)
  );

  assign victim_way = victim_w;

endmodule

// File: rtl/plru4_tracker_chk.sv
module plru4_tracker_chk #(
  parameter int SET_W = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             upd_valid,
  input logic [SET_W-1:0] upd_set,
  input logic [1:0]       upd_way,
  input logic [SET_W-1:0] qry_set,
  input logic [1:0]       victim_way
);

  // R9
  last_way_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_valid |=> ((qry_set != $past(upd_set)) || (victim_way != $past(upd_way))));

  // R3
  pair_ab_moves_away_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (upd_valid && !upd_way[1]) |=> ((qry_set != $past(upd_set)) || victim_way[1]));

  // R5
  pair_cd_moves_away_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (upd_valid && upd_way[1]) |=> ((qry_set != $past(upd_set)) || !victim_way[1]));

  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !upd_valid |=> (!$stable(qry_set) || $stable(victim_way)));

  // R6
  other_set_holds_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (upd_valid && (upd_set != qry_set)) |=> (!$stable(qry_set) || $stable(victim_way)));

endmodule

bind plru4_tracker plru4_tracker_chk #(.SET_W(SET_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .upd_valid  (upd_valid),
  .upd_set    (upd_set),
  .upd_way    (upd_way),
  .qry_set    (qry_set),
  .victim_way (victim_way)
);

// File: tb/plru4_tracker_tb.sv
`timescale 1ns/1ps
module plru4_tracker_tb;

  localparam int NSETS = 16;
  localparam int SW    = $clog2(NSETS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          upd_valid;
  logic [SW-1:0] upd_set;
  logic [1:0]    upd_way;
  logic [SW-1:0] qry_set;
  logic [1:0]    victim_way;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  logic [2:0] mdl [NSETS];
  bit         last_v;
  int         last_set;
  int         last_way;

  always #2 clk = ~clk;

  plru4_tracker #(.NUM_SETS(NSETS)) u_dut (
    .clk (clk), .rst_n (rst_n), .upd_valid (upd_valid), .upd_set (upd_set),
    .upd_way (upd_way), .qry_set (qry_set), .victim_way (victim_way)
  );

  function automatic int vict(logic [2:0] b);
    if (b[0]) return b[2] ? 3 : 2;
    return b[1] ? 1 : 0;
  endfunction

  function automatic logic [2:0] nxt(logic [2:0] b, int w);
    case (w)
      0: return {b[2], 1'b1, 1'b1};
      1: return {b[2], 1'b0, 1'b1};
      2: return {1'b1, b[1], 1'b0};
      default: return {1'b0, b[1], 1'b0};
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one cycle: drive, check pre-update victim, clock, update model
  task automatic apply(bit v, int s, int w, int q, string tag);
    @(negedge clk);
    upd_valid = v; upd_set = SW'(s); upd_way = 2'(w); qry_set = SW'(q);
    #1;
    check(tag, int'(victim_way), vict(mdl[q]));
    if (last_v && q == last_set && victim_way == 2'(last_way)) begin
      n_fail++;
      $display("FAIL R9: got %0d expected not %0d", victim_way, last_way);
    end
    @(posedge clk);
    if (v) mdl[s] = nxt(mdl[s], w);
    last_v = v; last_set = s; last_way = w;
  endtask

  task automatic peek(int q, int exp, string tag);
    @(negedge clk);
    upd_valid = 1'b0; qry_set = SW'(q);
    #1;
    check(tag, int'(victim_way), exp);
    last_v = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; upd_valid = 1'b0; upd_set = '0; upd_way = '0; qry_set = '0;
    for (int i = 0; i < NSETS; i++) mdl[i] = 3'b000;
    last_v = 1'b0; last_set = 0; last_way = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NSETS; i++) peek(i, 0, "R1");

    apply(1, 0, 1, 0, "R8");
    peek(0, 2, "R4");

    apply(1, 1, 0, 1, "R8");
    peek(1, 2, "R3 way0");
    apply(1, 1, 2, 1, "R8");
    peek(1, 1, "R5 way2");
    apply(1, 1, 3, 1, "R8");
    peek(1, 1, "R5 way3");
    apply(1, 1, 1, 1, "R8");
    peek(1, 2, "R3 way1");
    apply(1, 1, 2, 1, "R8");
    peek(1, 0, "R2 state100");
    apply(1, 1, 0, 1, "R8");
    peek(1, 3, "R2 state111");

    peek(2, 0, "R6");

    apply(1, 3, 0, 3, "R8");
    apply(0, 3, 2, 3, "R7");
    peek(3, 2, "R7");

    @(negedge clk);
    upd_valid = 1'b1; upd_set = SW'(4); upd_way = 2'd0; qry_set = SW'(4);
    #1;
    check("R8 same-cycle", int'(victim_way), 0);
    @(posedge clk);
    mdl[4] = nxt(mdl[4], 0);
    peek(4, 2, "R8 next-cycle");

    lfsr = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      int s, w, q;
      bit v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = lfsr[0] | lfsr[1];
      s = int'(lfsr[5:2]);
      w = int'(lfsr[7:6]);
      q = (k % 2 == 0) ? last_set : int'(lfsr[11:8]);
      apply(v, s, w, q, "R2 R6 R7 sweep");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule